// File: doc/BRIEF.md
# Quadword Integer Comparator

This block compares two 128-bit integers, read either as unsigned or as two's-complement values, and returns its verdict in two forms. A three-way compare yields a 4-bit condition nibble holding less-than, greater-than and equal flags, steered to a condition slot chosen by a 3-bit index. An equal test or a greater-than test yields a 128-bit lane mask of all ones or all zeros. With recording enabled, the test can also post its flag to the fixed condition slot 6.

The wide compare is assembled from two 64-bit half comparators. Only the upper half uses the signed relation. The lower half is always unsigned, because it carries no sign of its own. Each request is accepted on a one-cycle valid strobe and answered exactly one clock later. Register-file storage lies outside the block: the consumer writes the condition nibble when the write-enable is high.

Top module: `qcmp_quad`

## Requirements
- R1: Two operands count as equal only when the upper 64-bit halves match and the lower 64-bit halves also match.
- R2: With `is_signed` low, A > B holds when upper(A) > upper(B) unsigned, or the upper halves match and lower(A) > lower(B) unsigned.
- R3: With `is_signed` high, A > B holds when upper(A) > upper(B) as signed 64-bit values, or the upper halves match and lower(A) > lower(B) as unsigned values. Less-than is greater-than with the operands swapped.
- R4: `op_sel` = 0 (three-way) raises `cond_we`, returns `cond_idx` = `fld_idx`, and returns `cond_val` with less-than in bit 3, greater-than in bit 2, equal in bit 1 and bit 0 zero. `vec_res` is zero.
- R5: `op_sel` = 1 (equal test, `is_signed` ignored) and `op_sel` = 2 (greater-than test) return `vec_res` all ones when the test holds and all zeros when it fails.
- R6: With `rec_en` high, the equal test raises `cond_we` with `cond_idx` = 6 and `cond_val` = {0,0,eq,0}. The greater-than test does the same with `cond_val` = {0,gt,0,0}.
- R7: With `rec_en` low, the equal and greater-than tests leave `cond_we` low.
- R8: Results appear one clock after `in_valid`. `out_valid` is low in any cycle that follows one without `in_valid`. `cond_we` is never high without `out_valid`.
- R9: `op_sel` = 3 is reserved. It raises `out_valid` with `cond_we` low and `vec_res` zero.
- R10: Under reset, `out_valid`, `cond_we`, `vec_res`, `cond_val` and `cond_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_a | input | 128 | Operand A |
| op_b | input | 128 | Operand B |
| op_sel | input | 2 | 0 three-way, 1 equal, 2 greater-than, 3 reserved |
| is_signed | input | 1 | Treat operands as two's complement |
| rec_en | input | 1 | Record the flag of an equal/greater-than test |
| fld_idx | input | 3 | Target slot for the three-way compare |
| out_valid | output | 1 | Result strobe |
| vec_res | output | 128 | Lane mask result |
| cond_val | output | 4 | Condition nibble |
| cond_idx | output | 3 | Condition slot index |
| cond_we | output | 1 | Condition write-enable |

## Verification
The bench builds the block with its default 64-bit halves, so the operand width is 128 bits and the record slot is 6. At this width the bench reaches the extreme values directly: the most-negative and the most-positive quadwords, whose order flips between signed and unsigned modes. It also reaches operand pairs whose negative upper halves match and whose lower halves differ across bit 63, which exercises the unsigned treatment of the lower half inside a signed compare.

// File: rtl/qcmp_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes and widths for the quadword comparator.
// Assumes the operand is exactly two halves of HALF_W bits each.
package qcmp_pkg;
    localparam int HALF_W    = 64;
    localparam int QUAD_W    = 2 * HALF_W;
    localparam int IDX_W     = 3;
    localparam int COND_W    = 4;
    localparam int REC_FIELD = 6;

    typedef enum logic [1:0] {
        OP_FULL = 2'd0,
        OP_EQ   = 2'd1,
        OP_GT   = 2'd2,
        OP_RSV  = 2'd3
    } qcmp_op_e;

    // Raw flags produced by the comparison datapath.
    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } qcmp_flags_t;
endpackage

// File: rtl/qcmp_half_cmp.sv
`timescale 1ns/1ps
// Module: qcmp_half_cmp
// Compares one half-width slice of the two operands. It reports equality and
// both orderings, using the signed relation when sgn is high.
// Assumes: purely combinational; the caller decides which slice is signed.
module qcmp_half_cmp #(
    parameter int HW = 64
) (
    input  logic [HW-1:0] a,
    input  logic [HW-1:0] b,
    input  logic          sgn,
    output logic          eq,
    output logic          gt,
    output logic          lt
);
    // Purpose: evaluate the slice relations in the selected number domain.
    always_comb begin
        eq = (a == b);
        if (sgn) begin
            gt = ($signed(a) > $signed(b));
            lt = ($signed(a) < $signed(b));
        end else begin
            gt = (a > b);
            lt = (a < b);
        end
    end
endmodule

// File: rtl/qcmp_core.sv
`timescale 1ns/1ps
// Module: qcmp_core
// Builds the full-width relations from two half comparators. The upper half
// follows the sign mode; the lower half is always unsigned.
// Assumes: combinational; a and b are QW = 2*HW bits wide.
module qcmp_core #(
    parameter int HW = 64,
    localparam int QW = 2 * HW,
    localparam int NH = 2
) (
    input  logic [QW-1:0]       a,
    input  logic [QW-1:0]       b,
    input  logic                sgn,
    output qcmp_pkg::qcmp_flags_t flags
);
    logic [NH-1:0] h_eq;
    logic [NH-1:0] h_gt;
    logic [NH-1:0] h_lt;

    // One comparator per half; index NH-1 is the sign-bearing upper half.
    for (genvar h = 0; h < NH; h++) begin : g_half
        qcmp_half_cmp #(.HW(HW)) u_cmp (
            .a   (a[h*HW +: HW]),
            .b   (b[h*HW +: HW]),
            .sgn ((h == NH-1) ? sgn : 1'b0),
            .eq  (h_eq[h]),
            .gt  (h_gt[h]),
            .lt  (h_lt[h])
        );
    end

    // Purpose: merge half relations, the upper half deciding unless tied.
    always_comb begin
        flags.eq = h_eq[1] & h_eq[0];
        flags.gt = h_gt[1] | (h_eq[1] & h_gt[0]);
        flags.lt = h_lt[1] | (h_eq[1] & h_lt[0]);
    end
endmodule

// File: rtl/qcmp_encode.sv
`timescale 1ns/1ps
// Module: qcmp_encode
// Turns the raw flags and the operation code into the mask bit, the
// condition nibble, its slot index and its write-enable.
// Assumes: combinational; the caller registers the results.
module qcmp_encode #(
    parameter int IW  = 3,
    parameter int REC = 6,
    localparam int CW = 4
) (
    input  logic [1:0]            op,
    input  logic                  rec,
    input  logic [IW-1:0]         idx,
    input  qcmp_pkg::qcmp_flags_t flags,
    output logic                  mask_bit,
    output logic [CW-1:0]         cval,
    output logic [IW-1:0]         cidx,
    output logic                  cwe
);
    import qcmp_pkg::*;

    // Purpose: select the result encoding for each operation form.
    always_comb begin
        mask_bit = 1'b0;
        cval     = '0;
        cidx     = IW'(REC);
        cwe      = 1'b0;
        case (qcmp_op_e'(op))
            OP_FULL: begin
                cval = {flags.lt, flags.gt, flags.eq, 1'b0};
                cidx = idx;
                cwe  = 1'b1;
            end
            OP_EQ: begin
                mask_bit = flags.eq;
                cval     = {2'b00, flags.eq, 1'b0};
                cwe      = rec;
            end
            OP_GT: begin
                mask_bit = flags.gt;
                cval     = {1'b0, flags.gt, 2'b00};
                cwe      = rec;
            end
            default: begin
                cwe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qcmp_quad.sv
`timescale 1ns/1ps
// Module: qcmp_quad (top)
// Quadword integer comparator with one register stage. A request that is
// accepted on in_valid is answered on the next clock with out_valid.
// Assumes: synchronous active-low reset; the consumer owns condition storage.
module qcmp_quad #(
    parameter int HALF_W    = qcmp_pkg::HALF_W,
    parameter int IDX_W     = qcmp_pkg::IDX_W,
    parameter int REC_FIELD = qcmp_pkg::REC_FIELD,
    localparam int W        = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [1:0]       op_sel,
    input  logic             is_signed,
    input  logic             rec_en,
    input  logic [IDX_W-1:0] fld_idx,
    output logic             out_valid,
    output logic [W-1:0]     vec_res,
    output logic [3:0]       cond_val,
    output logic [IDX_W-1:0] cond_idx,
    output logic             cond_we
);
    qcmp_pkg::qcmp_flags_t flags;
    logic                  mask_bit;
    logic [3:0]            cval_d;
    logic [IDX_W-1:0]      cidx_d;
    logic                  cwe_d;

    qcmp_core #(.HW(HALF_W)) u_core (
        .a     (op_a),
        .b     (op_b),
        .sgn   (is_signed),
        .flags (flags)
    );

    qcmp_encode #(.IW(IDX_W), .REC(REC_FIELD)) u_enc (
        .op       (op_sel),
        .rec      (rec_en),
        .idx      (fld_idx),
        .flags    (flags),
        .mask_bit (mask_bit),
        .cval     (cval_d),
        .cidx     (cidx_d),
        .cwe      (cwe_d)
    );

    // Purpose: register the strobes, qualifying the write-enable by valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cond_we   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            cond_we   <= in_valid & cwe_d;
        end
    end

    // Purpose: capture result data only on accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_res  <= '0;
            cond_val <= '0;
            cond_idx <= '0;
        end else if (in_valid) begin
            vec_res  <= {W{mask_bit}};
            cond_val <= cval_d;
            cond_idx <= cidx_d;
        end
    end
endmodule

// File: rtl/qcmp_quad_chk.sv
`timescale 1ns/1ps
// Module: qcmp_quad_chk
// Protocol and encoding properties of the comparator, bound to the top.
module qcmp_quad_chk #(
    parameter int W         = 128,
    parameter int IDX_W     = 3,
    parameter int REC_FIELD = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op_sel,
    input logic             rec_en,
    input logic             out_valid,
    input logic [W-1:0]     vec_res,
    input logic [3:0]       cond_val,
    input logic [IDX_W-1:0] cond_idx,
    input logic             cond_we
);
    assert_we_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> out_valid);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !cond_we));
    assert_mask_solid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (vec_res == '0 || vec_res == '1));
    assert_full_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0) |=>
            (cond_we && vec_res == '0 && !cond_val[0] && $onehot(cond_val[3:1])));
    assert_record_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 2'd1 || op_sel == 2'd2) && rec_en) |=>
            (cond_we && cond_idx == IDX_W'(REC_FIELD) && $onehot0(cond_val)));
    assert_no_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'd0 && !rec_en) |=> !cond_we);
    assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3) |=> (!cond_we && vec_res == '0));
endmodule

bind qcmp_quad qcmp_quad_chk #(.W(W), .IDX_W(IDX_W), .REC_FIELD(REC_FIELD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .rec_en    (rec_en),
    .out_valid (out_valid),
    .vec_res   (vec_res),
    .cond_val  (cond_val),
    .cond_idx  (cond_idx),
    .cond_we   (cond_we)
);

// File: tb/sim_qcmp_quad.sv
`timescale 1ns/1ps
module sim_qcmp_quad;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [1:0]   op_sel = 2'd0;
    logic         is_signed = 1'b0;
    logic         rec_en = 1'b0;
    logic [2:0]   fld_idx = 3'd0;
    logic         out_valid;
    logic [W-1:0] vec_res;
    logic [3:0]   cond_val;
    logic [2:0]   cond_idx;
    logic         cond_we;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    always #2.5 clk = ~clk;

    qcmp_quad u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .op_sel(op_sel), .is_signed(is_signed), .rec_en(rec_en), .fld_idx(fld_idx),
        .out_valid(out_valid), .vec_res(vec_res), .cond_val(cond_val),
        .cond_idx(cond_idx), .cond_we(cond_we)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request, then sample the registered answer one clock later.
    task automatic run_op(string req, logic [W-1:0] a, logic [W-1:0] b,
                          logic [1:0] op, logic sg, logic rec, logic [2:0] idx);
        logic eq, gt, lt, ewe;
        logic [W-1:0] ev;
        logic [3:0] ecv;
        logic [2:0] eidx;
        eq = (a == b);
        gt = sg ? ($signed(a) > $signed(b)) : (a > b);
        lt = sg ? ($signed(a) < $signed(b)) : (a < b);
        ev = '0; ecv = 4'd0; ewe = 1'b0; eidx = 3'd6;
        case (op)
            2'd0: begin ecv = {lt, gt, eq, 1'b0}; ewe = 1'b1; eidx = idx; end
            2'd1: begin ev = {W{eq}}; ecv = {2'b00, eq, 1'b0}; ewe = rec; end
            2'd2: begin ev = {W{gt}}; ecv = {1'b0, gt, 2'b00}; ewe = rec; end
            default: ;
        endcase
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; is_signed = sg; rec_en = rec;
        fld_idx = idx; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, W'(out_valid), W'(1'b1));
        check({req, " vec"}, vec_res, ev);
        check({req, " we"}, W'(cond_we), W'(ewe));
        if (ewe) begin
            check({req, " cval"}, W'(cond_val), W'(ecv));
            check({req, " cidx"}, W'(cond_idx), W'(eidx));
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R10 valid", W'(out_valid), '0);
        check("R10 we", W'(cond_we), '0);
        check("R10 vec", vec_res, '0);
        check("R10 cval", W'(cond_val), '0);
        check("R10 cidx", W'(cond_idx), '0);
        rst_n = 1'b1;
    endtask

    task automatic t_equality;
        run_op("R1 same", 128'h1234_5678_9abc_def0_0fed_cba9_8765_4321,
               128'h1234_5678_9abc_def0_0fed_cba9_8765_4321, 2'd0, 1'b0, 1'b0, 3'd2);
        run_op("R1 lowdiff", {64'hAA, 64'h1}, {64'hAA, 64'h2}, 2'd1, 1'b0, 1'b1, 3'd0);
        run_op("R1 highdiff", {64'hAB, 64'h7}, {64'hAA, 64'h7}, 2'd1, 1'b1, 1'b1, 3'd0);
        run_op("R1 eqtrue", {64'h5, 64'h9}, {64'h5, 64'h9}, 2'd1, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic t_unsigned;
        run_op("R2 hi", {64'h8000_0000_0000_0000, 64'h0}, {64'h1, 64'hFFFF_FFFF_FFFF_FFFF},
               2'd0, 1'b0, 1'b0, 3'd5);
        run_op("R2 lo", {64'h3, 64'h10}, {64'h3, 64'h11}, 2'd0, 1'b0, 1'b0, 3'd1);
        run_op("R2 gtform", {64'h3, 64'hF000_0000_0000_0000}, {64'h3, 64'h1},
               2'd2, 1'b0, 1'b1, 3'd1);
    endtask

    task automatic t_signed;
        run_op("R3 neghi", {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, {64'h1, 64'h0},
               2'd0, 1'b1, 1'b0, 3'd7);
        run_op("R3 negtie_lo", {64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0001},
               {64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0005}, 2'd0, 1'b1, 1'b0, 3'd3);
        run_op("R3 negtie_gt", {64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0001},
               {64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0005}, 2'd2, 1'b1, 1'b1, 3'd3);
        run_op("R3 negtie_swap", {64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0005},
               {64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0001}, 2'd2, 1'b1, 1'b1, 3'd3);
    endtask

    task automatic t_extremes;
        run_op("R3 minmax_s", MOST_NEG, MOST_POS, 2'd0, 1'b1, 1'b0, 3'd4);
        run_op("R2 minmax_u", MOST_NEG, MOST_POS, 2'd0, 1'b0, 1'b0, 3'd4);
        run_op("R5 minmax_gt_s", MOST_POS, MOST_NEG, 2'd2, 1'b1, 1'b0, 3'd0);
        run_op("R5 minmax_gt_u", MOST_POS, MOST_NEG, 2'd2, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_full_fields;
        for (int i = 0; i < 8; i++)
            run_op("R4 slot", W'(i), 128'd3, 2'd0, i[0], 1'b1, i[2:0]);
    endtask

    task automatic t_record;
        run_op("R6 eq_rec", 128'd42, 128'd42, 2'd1, 1'b0, 1'b1, 3'd1);
        run_op("R6 gt_rec", 128'd43, 128'd42, 2'd2, 1'b0, 1'b1, 3'd2);
        run_op("R6 gt_false", 128'd41, 128'd42, 2'd2, 1'b0, 1'b1, 3'd2);
        run_op("R7 eq_norec", 128'd42, 128'd42, 2'd1, 1'b0, 1'b0, 3'd1);
        run_op("R7 gt_norec", 128'd43, 128'd42, 2'd2, 1'b1, 1'b0, 3'd1);
    endtask

    task automatic t_reserved;
        run_op("R9 rsv", 128'd7, 128'd7, 2'd3, 1'b0, 1'b1, 3'd6);
    endtask

    task automatic t_idle;
        run_op("R8 lead", 128'd1, 128'd0, 2'd0, 1'b0, 1'b0, 3'd2);
        @(negedge clk);
        check("R8 idle valid", W'(out_valid), '0);
        check("R8 idle we", W'(cond_we), '0);
    endtask

    initial begin
        t_reset();
        t_equality();
        t_unsigned();
        t_signed();
        t_extremes();
        t_full_fields();
        t_record();
        t_reserved();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule